// File: doc/BRIEF.md
# Pseudorandom Down-Spread Modulation Code Generator

This block produces the digital word that sets how far a spread-spectrum oscillator is pulled below its nominal frequency. A 9-bit maximal-length shift register steps once on each shift strobe. The low seven bits of the new state become a parallel modulation code, so the level moves in 128 discrete steps and stays constant between strobes. A downstream converter turns this word into an analog offset. Code zero means no offset, which is the highest frequency. The full-scale code means the largest downward offset, 20 percent below the highest frequency. The offset only ever lowers the frequency.

A 4-bit depth input reduces the spread by scaling the code. A disable input freezes the register and forces the code to zero, which is the hard-off path for the modulation. A code-valid strobe flags each new word. A period-start pulse marks each return of the register to its seed, once every 511 shifts.

Top module: `ssm_code_gen`

## Requirements
- R1: The state register is 9 bits wide. On each shift it moves one place toward the MSB, and the new LSB is state[8] XOR state[4] (polynomial x^9+x^5+1). It never holds zero, and it visits 511 distinct states before it repeats.
- R2: `period_start` is high for exactly the one cycle that follows a shift which brings the state back to the seed 9'h1FF. This happens once every 511 shifts.
- R3: A shift takes place in a cycle with `shift_en`=1 and `mod_off`=0. In the next cycle, `code` equals the scaled value of bits [6:0] of the new state, and `code_vld` is 1 for that one cycle. The first shift after reset gives state 9'h1FE, which is raw code 7'h7E.
- R4: In a cycle with `shift_en`=0 and `mod_off`=0, the state does not change. In the next cycle `code` holds its value and `code_vld` is 0.
- R5: While `mod_off`=1, the state does not shift, whatever `shift_en` is. In the next cycle `code` is 0 and `code_vld` is 0. The code stays 0 until the first shift after `mod_off` returns to 0. The sequence then resumes from the state at which it stopped.
- R6: The scaled code is floor(raw * depth / 15). With `depth`=15 it equals the raw code, and with `depth`=0 it is 0. Depth is sampled only in the shift cycle.
- R7: After a synchronous reset, the state is 9'h1FF and `code`, `code_vld` and `period_start` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift strobe; one register step per high cycle |
| mod_off | input | 1 | Modulation disable; freezes the state and zeroes the code |
| depth | input | 4 | Spread depth, 0 to 15 |
| code | output | 7 | Registered modulation code to the converter |
| code_vld | output | 1 | One-cycle flag marking a new code |
| period_start | output | 1 | One-cycle flag marking a return to the seed |

## Verification
The assertions assume that `shift_en`, `mod_off` and `depth` are synchronous to `clk` and stable around each rising edge. They also assume that reset is held for at least one edge before checking starts. The bench changes every input half a cycle away from the rising edge. It draws `shift_en`, `mod_off` and `depth` from a seeded $urandom and mixes in directed cases: depth 0 and 15, a long disable with strobes still arriving, and a full 511-shift period with the disable held low.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int unsigned STATE_W = 9;
  localparam int unsigned CODE_W  = 7;
  localparam int unsigned DEPTH_W = 4;
  localparam logic [STATE_W-1:0] SEED = 9'h1FF;
  localparam int unsigned TAP_HI = 8;
  localparam int unsigned TAP_LO = 4;
endpackage

// File: rtl/ssm_lfsr.sv
module ssm_lfsr #(
  parameter int unsigned W      = ssm_pkg::STATE_W,
  parameter int unsigned TAP_HI = ssm_pkg::TAP_HI,
  parameter int unsigned TAP_LO = ssm_pkg::TAP_LO,
  parameter logic [W-1:0] SEED  = ssm_pkg::SEED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] nxt,
  output logic [W-1:0] state
);
  logic [W-1:0] shifted;

  always_comb begin
    shifted = {state[W-2:0], state[TAP_HI] ^ state[TAP_LO]};
    nxt     = (shifted == '0) ? SEED : shifted;
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= SEED;
    else if (step) state <= nxt;
  end

  p_nonzero_r1: assert property (@(posedge clk) disable iff (rst) state != '0);
  p_freeze_r4: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(state));
endmodule

// File: rtl/ssm_scaler.sv
module ssm_scaler #(
  parameter int unsigned CODE_W  = ssm_pkg::CODE_W,
  parameter int unsigned DEPTH_W = ssm_pkg::DEPTH_W
) (
  input  logic [CODE_W-1:0]  raw,
  input  logic [DEPTH_W-1:0] depth,
  output logic [CODE_W-1:0]  scaled
);
  localparam int unsigned PROD_W = CODE_W + DEPTH_W;
  localparam logic [PROD_W-1:0] DMAX = PROD_W'((1 << DEPTH_W) - 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    prod   = PROD_W'(raw) * PROD_W'(depth);
    quot   = prod / DMAX;
    scaled = quot[CODE_W-1:0];
    p_scale_bound_r6: assert (scaled <= raw);
  end
endmodule

// File: rtl/ssm_out_reg.sv
module ssm_out_reg #(
  parameter int unsigned CODE_W = ssm_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic [CODE_W-1:0] din,
  input  logic              wrap,
  output logic [CODE_W-1:0] code,
  output logic              code_vld,
  output logic              period_start
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code         <= '0;
      code_vld     <= 1'b0;
      period_start <= 1'b0;
    end else begin
      code_vld     <= load;
      period_start <= load & wrap;
      if (clear)     code <= '0;
      else if (load) code <= din;
    end
  end

  p_mark_vld_r2: assert property (@(posedge clk) disable iff (rst) period_start |-> code_vld);
endmodule

// File: rtl/ssm_code_gen.sv
module ssm_code_gen #(
  parameter int unsigned STATE_W = ssm_pkg::STATE_W,
  parameter int unsigned CODE_W  = ssm_pkg::CODE_W,
  parameter int unsigned DEPTH_W = ssm_pkg::DEPTH_W,
  parameter logic [STATE_W-1:0] SEED = ssm_pkg::SEED
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               mod_off,
  input  logic [DEPTH_W-1:0] depth,
  output logic [CODE_W-1:0]  code,
  output logic               code_vld,
  output logic               period_start
);
  logic               step;
  logic [STATE_W-1:0] nxt;
  logic [STATE_W-1:0] state;
  logic [CODE_W-1:0]  scaled;

  assign step = shift_en & ~mod_off;

  ssm_lfsr #(.W(STATE_W), .TAP_HI(ssm_pkg::TAP_HI), .TAP_LO(ssm_pkg::TAP_LO), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(step), .nxt(nxt), .state(state)
  );

  ssm_scaler #(.CODE_W(CODE_W), .DEPTH_W(DEPTH_W)) u_scale (
    .raw(nxt[CODE_W-1:0]), .depth(depth), .scaled(scaled)
  );

  ssm_out_reg #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst(rst), .load(step), .clear(mod_off), .din(scaled),
    .wrap(nxt == SEED), .code(code), .code_vld(code_vld), .period_start(period_start)
  );

  p_off_zero_r5: assert property (@(posedge clk) disable iff (rst) mod_off |=> (code == '0) && !code_vld);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst) (!shift_en && !mod_off) |=> $stable(code) && !code_vld);
  p_full_depth_r3: assert property (@(posedge clk) disable iff (rst)
    (step && depth == DEPTH_W'((1 << DEPTH_W) - 1)) |=> code == state[CODE_W-1:0]);
endmodule

// File: tb/tb_ssm_code_gen.sv
module tb_ssm_code_gen;
  logic       clk = 0;
  logic       rst = 1;
  logic       shift_en = 0;
  logic       mod_off = 0;
  logic [3:0] depth = 4'd15;
  logic [6:0] code;
  logic       code_vld;
  logic       period_start;

  int n_chk = 0;
  int n_bad = 0;
  logic [8:0] m_st;
  logic [6:0] m_code;

  always #2.5 clk = ~clk;

  ssm_code_gen dut (.clk(clk), .rst(rst), .shift_en(shift_en), .mod_off(mod_off),
    .depth(depth), .code(code), .code_vld(code_vld), .period_start(period_start));

  function automatic logic [8:0] f_next(input logic [8:0] s);
    logic [8:0] n;
    n = {s[7:0], s[8] ^ s[4]};
    return (n == 9'h0) ? 9'h1FF : n;
  endfunction

  function automatic logic [6:0] f_scale(input logic [6:0] c, input logic [3:0] d);
    int unsigned p;
    p = (int'(c) * int'(d)) / 15;
    return 7'(p);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, clock once, check at the next negedge
  task automatic step(input logic se, input logic off, input logic [3:0] d, input string req);
    logic ev, ew;
    shift_en = se; mod_off = off; depth = d;
    @(posedge clk);
    ev = se && !off;
    ew = 1'b0;
    if (ev) begin
      m_st = f_next(m_st);
      m_code = f_scale(m_st[6:0], d);
      ew = (m_st == 9'h1FF);
    end else if (off) m_code = 7'h0;
    @(negedge clk);
    chk({req, " code"}, int'(code), int'(m_code));
    chk({req, " vld"}, int'(code_vld), int'(ev));
    chk({req, " pstart"}, int'(period_start), int'(ew));
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_st = 9'h1FF; m_code = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R7 reset state
    chk("R7 code", int'(code), 0);
    chk("R7 vld", int'(code_vld), 0);
    chk("R7 pstart", int'(period_start), 0);
    // R3 first shift gives 7E
    step(1, 0, 4'd15, "R3");
    chk("R3 first code", int'(code), 'h7E);
    // R4 idle hold
    step(0, 0, 4'd3, "R4");
    step(0, 0, 4'd0, "R4");
    // R6 depth corners
    step(1, 0, 4'd0, "R6");
    chk("R6 depth0 zero", int'(code), 0);
    step(1, 0, 4'd7, "R6");
    // R5 disable with strobes arriving, then resume
    for (int i = 0; i < 20; i++) step(1'(i % 2), 1, 4'd15, "R5");
    step(0, 0, 4'd15, "R5");
    chk("R5 held zero after release", int'(code), 0);
    step(1, 0, 4'd15, "R5");
    // R1/R2 full period: resync to seed by reset
    rst = 1; @(negedge clk); rst = 0;
    m_st = 9'h1FF; m_code = 0;
    begin
      bit seen [512];
      int first_wrap;
      int rep;
      first_wrap = 0; rep = 0;
      seen[9'h1FF] = 1;
      for (int i = 1; i <= 520; i++) begin
        step(1, 0, 4'd15, "R1");
        if (period_start && first_wrap == 0) first_wrap = i;
        if (i < 511) begin
          if (seen[m_st]) rep++;
          seen[m_st] = 1;
        end
      end
      chk("R2 period length", first_wrap, 511);
      chk("R1 no repeated state", rep, 0);
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic se, off;
      logic [3:0] d;
      se = ($urandom % 2) == 0;
      off = ($urandom % 8) == 0;
      d = 4'($urandom % 16);
      step(se, off, d, "R3/R6 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule